// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block computes the control-register updates a soft processor makes when it enters an exception or interrupt handler. On a take strobe it looks at a pending synchronous exception (a class and a 5-bit cause code) and a pending external interrupt. It picks the winner and writes, on one clock edge, the new status word, the saved-status copy, the exception register, the TLB-miscellaneous register, the return address, the bad-address register and the redirected program counter.

The live status, exception and TLB-miscellaneous values come in from the processor's register file, and the block presents their next values. The saved copies (exception status and return address, break status and break return address, bad address) are held inside the block and change only when an entry writes them. Handling differs by class. A TLB miss goes to a separate fast vector unless an exception is already being handled. A break saves into its own register pair. Nested entries leave the saved copies alone.

Top module: `exc_seq_top`

## Requirements
- R1: With take_i high, no synchronous request, irq_i high and status_i bit 0 (interrupt enable) set, the block takes an interrupt. It copies status_i to estatus_o and writes ea_o = pc_i + 4. status_o is status_i with bit 3 (interrupt-handler flag) set and bits 0 and 1 (user mode) cleared. The cause is IRQ_CAUSE (default 2), and pc_o becomes EXC_VEC.
- R2: For each taken entry other than an unaligned access, exc_o bits [6:2] hold the cause code and every other bit equals exc_i.
- R3: A TLB miss (class 0) taken while status_i bit 2 (EH) is clear saves estatus_o and ea_o = pc_i + 4. It sets EH, clears bits 0 and 1, clears tlbmisc bit 14 (double-miss flag), sets tlbmisc bit 18 (write flag) and loads FAST_VEC into pc_o.
- R4: A TLB miss taken with EH set leaves estatus_o and ea_o unchanged and sets tlbmisc bit 14, leaving bit 18 as it came in. It sets EH, clears bits 0 and 1 and loads EXC_VEC.
- R5: Supervisor-only (class 1), trap (class 2) and illegal-instruction (class 3) entries save estatus_o and ea_o = pc_i + 4 only when EH was clear. They always set EH, clear bits 0 and 1 and load EXC_VEC.
- R6: A break (class 4) saves status_i into bstatus_o and pc_i + 4 into ba_o, only when EH was clear. It never touches estatus_o or ea_o and otherwise acts as a trap.
- R7: An unaligned access (class 5) loads fault_addr_i into badaddr_o and replaces all of exc_o with the cause shifted left by 2. For status, estatus_o, ea_o and pc_o it acts as a trap. No other class changes badaddr_o.
- R8: A synchronous request beats an interrupt in the same cycle. An interrupt with status_i bit 0 clear is not taken. A request with class 6 or 7 is dropped, and no interrupt is taken in that cycle either.
- R9: Nothing changes unless take_i is high. taken_o pulses for one cycle after each committed entry. Reset clears every output register, leaving supervisor mode with interrupts disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| take_i | input | 1 | Entry strobe |
| exc_req_i | input | 1 | Synchronous exception pending |
| exc_class_i | input | 3 | Exception class code |
| exc_cause_i | input | 5 | Cause code of the synchronous exception |
| irq_i | input | 1 | External interrupt pending |
| pc_i | input | DATA_W | PC of the faulting instruction |
| status_i | input | DATA_W | Current status register |
| exc_i | input | DATA_W | Current exception register |
| tlbmisc_i | input | DATA_W | Current TLB-miscellaneous register |
| fault_addr_i | input | DATA_W | Faulting data address |
| taken_o | output | 1 | Entry committed on the previous edge |
| pc_o | output | DATA_W | Handler vector |
| status_o | output | DATA_W | Next status |
| estatus_o | output | DATA_W | Saved status for exceptions and interrupts |
| bstatus_o | output | DATA_W | Saved status for breaks |
| exc_o | output | DATA_W | Next exception register |
| tlbmisc_o | output | DATA_W | Next TLB-miscellaneous register |
| ea_o | output | DATA_W | Exception return address |
| ba_o | output | DATA_W | Break return address |
| badaddr_o | output | DATA_W | Bad-address register |

## Verification
The hardest cases to reach are the nested entries, where EH is already set and the saved copies must stay as they are. A port-level run only shows a stale value if the registers held something different beforehand. So the vector table puts an entry with EH clear, which fills estatus, ea, bstatus and ba with values tied to that vector's PC and status, right before each nested entry of the same kind. The check that nothing changed then compares against values that differ from what a wrongful save would write. The double miss is driven with the write flag clear and the double flag clear, and the fast miss with the double flag set, so each TLB-flag change is visible.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int unsigned CAUSE_W   = 5;
  localparam int unsigned CAUSE_LSB = 2;
  localparam int unsigned ST_PIE    = 0;
  localparam int unsigned ST_U      = 1;
  localparam int unsigned ST_EH     = 2;
  localparam int unsigned ST_IH     = 3;

  typedef enum logic [2:0] {
    CLS_TLB_MISS = 3'd0,
    CLS_SUPER    = 3'd1,
    CLS_TRAP     = 3'd2,
    CLS_ILLEGAL  = 3'd3,
    CLS_BREAK    = 3'd4,
    CLS_UNALIGN  = 3'd5
  } exc_class_e;

  typedef enum logic [1:0] {EV_NONE, EV_IRQ, EV_SYNC} ev_kind_e;
  typedef enum logic {VEC_GEN, VEC_FAST} vec_sel_e;

  typedef struct packed {
    ev_kind_e             kind;
    exc_class_e           cls;
    logic [CAUSE_W-1:0]   cause;
  } ev_t;
endpackage

// File: rtl/exc_seq_arb.sv
module exc_seq_arb
  import exc_seq_pkg::*;
#(
  parameter int unsigned IRQ_CAUSE = 2
) (
  input  logic               take_i,
  input  logic               exc_req_i,
  input  logic [2:0]         exc_class_i,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic               irq_i,
  input  logic               irq_en_i,
  output ev_t                ev_o
);
  logic cls_ok;
  assign cls_ok = (exc_class_i <= 3'd5);

  always_comb begin
    ev_o.kind  = EV_NONE;
    ev_o.cls   = CLS_TRAP;
    ev_o.cause = '0;
    if (take_i) begin
      if (exc_req_i) begin
        // unknown classes are dropped and block the interrupt too
        if (cls_ok) begin
          ev_o.kind  = EV_SYNC;
          ev_o.cls   = exc_class_e'(exc_class_i);
          ev_o.cause = exc_cause_i;
        end
      end else if (irq_i && irq_en_i) begin
        ev_o.kind  = EV_IRQ;
        ev_o.cause = CAUSE_W'(IRQ_CAUSE);
      end
    end
  end
endmodule

// File: rtl/exc_seq_status.sv
module exc_seq_status
  import exc_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  ev_t               ev_i,
  input  logic [DATA_W-1:0] status_i,
  output logic [DATA_W-1:0] status_nxt_o,
  output logic              save_e_o,
  output logic              save_b_o,
  output vec_sel_e          vec_sel_o
);
  logic eh_prev;
  assign eh_prev = status_i[ST_EH];

  always_comb begin
    status_nxt_o         = status_i;
    status_nxt_o[ST_PIE] = 1'b0;
    status_nxt_o[ST_U]   = 1'b0;
    save_e_o             = 1'b0;
    save_b_o             = 1'b0;
    vec_sel_o            = VEC_GEN;
    unique case (ev_i.kind)
      EV_IRQ: begin
        status_nxt_o[ST_IH] = 1'b1;
        save_e_o            = 1'b1;
      end
      EV_SYNC: begin
        status_nxt_o[ST_EH] = 1'b1;
        unique case (ev_i.cls)
          CLS_TLB_MISS: begin
            save_e_o  = !eh_prev;
            vec_sel_o = eh_prev ? VEC_GEN : VEC_FAST;
          end
          CLS_BREAK: save_b_o = !eh_prev;
          default:   save_e_o = !eh_prev;
        endcase
      end
      default: status_nxt_o = status_i;
    endcase
  end
endmodule

// File: rtl/exc_seq_aux.sv
module exc_seq_aux
  import exc_seq_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DBL_BIT = 14,
  parameter int unsigned WR_BIT  = 18
) (
  input  ev_t               ev_i,
  input  logic              eh_prev_i,
  input  logic [DATA_W-1:0] exc_i,
  input  logic [DATA_W-1:0] tlbmisc_i,
  output logic [DATA_W-1:0] exc_nxt_o,
  output logic [DATA_W-1:0] tlbmisc_nxt_o,
  output logic              badaddr_we_o
);
  localparam logic [DATA_W-1:0] CAUSE_MASK =
    DATA_W'(((1 << CAUSE_W) - 1) << CAUSE_LSB);

  logic [DATA_W-1:0] cause_sh;
  logic              unal;

  assign cause_sh = DATA_W'(ev_i.cause) << CAUSE_LSB;
  assign unal     = (ev_i.kind == EV_SYNC) && (ev_i.cls == CLS_UNALIGN);

  always_comb begin
    if (unal) exc_nxt_o = cause_sh;
    else      exc_nxt_o = (exc_i & ~CAUSE_MASK) | cause_sh;
  end

  always_comb begin
    tlbmisc_nxt_o = tlbmisc_i;
    if (ev_i.kind == EV_SYNC && ev_i.cls == CLS_TLB_MISS) begin
      if (eh_prev_i) begin
        tlbmisc_nxt_o[DBL_BIT] = 1'b1;
      end else begin
        tlbmisc_nxt_o[DBL_BIT] = 1'b0;
        tlbmisc_nxt_o[WR_BIT]  = 1'b1;
      end
    end
  end

  assign badaddr_we_o = unal;
endmodule

// File: rtl/exc_seq_top.sv
module exc_seq_top
  import exc_seq_pkg::*;
#(
  parameter int unsigned       DATA_W    = 32,
  parameter logic [DATA_W-1:0] EXC_VEC   = 32'h0000_0820,
  parameter logic [DATA_W-1:0] FAST_VEC  = 32'h0000_0400,
  parameter int unsigned       IRQ_CAUSE = 2,
  parameter int unsigned       DBL_BIT   = 14,
  parameter int unsigned       WR_BIT    = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              exc_req_i,
  input  logic [2:0]        exc_class_i,
  input  logic [4:0]        exc_cause_i,
  input  logic              irq_i,
  input  logic [DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] exc_i,
  input  logic [DATA_W-1:0] tlbmisc_i,
  input  logic [DATA_W-1:0] fault_addr_i,
  output logic              taken_o,
  output logic [DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] estatus_o,
  output logic [DATA_W-1:0] bstatus_o,
  output logic [DATA_W-1:0] exc_o,
  output logic [DATA_W-1:0] tlbmisc_o,
  output logic [DATA_W-1:0] ea_o,
  output logic [DATA_W-1:0] ba_o,
  output logic [DATA_W-1:0] badaddr_o
);
  localparam logic [DATA_W-1:0] INSN_BYTES = DATA_W'(4);

  ev_t               ev;
  logic [DATA_W-1:0] status_nxt, exc_nxt, tlbmisc_nxt, ret_addr;
  logic              save_e, save_b, badaddr_we, fire;
  vec_sel_e          vec_sel;

  exc_seq_arb #(.IRQ_CAUSE(IRQ_CAUSE)) u_arb (
    .take_i      (take_i),
    .exc_req_i   (exc_req_i),
    .exc_class_i (exc_class_i),
    .exc_cause_i (exc_cause_i),
    .irq_i       (irq_i),
    .irq_en_i    (status_i[ST_PIE]),
    .ev_o        (ev)
  );

  exc_seq_status #(.DATA_W(DATA_W)) u_status (
    .ev_i         (ev),
    .status_i     (status_i),
    .status_nxt_o (status_nxt),
    .save_e_o     (save_e),
    .save_b_o     (save_b),
    .vec_sel_o    (vec_sel)
  );

  exc_seq_aux #(.DATA_W(DATA_W), .DBL_BIT(DBL_BIT), .WR_BIT(WR_BIT)) u_aux (
    .ev_i          (ev),
    .eh_prev_i     (status_i[ST_EH]),
    .exc_i         (exc_i),
    .tlbmisc_i     (tlbmisc_i),
    .exc_nxt_o     (exc_nxt),
    .tlbmisc_nxt_o (tlbmisc_nxt),
    .badaddr_we_o  (badaddr_we)
  );

  assign fire     = (ev.kind != EV_NONE);
  assign ret_addr = pc_i + INSN_BYTES;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o   <= 1'b0;
      pc_o      <= '0;
      status_o  <= '0;
      estatus_o <= '0;
      bstatus_o <= '0;
      exc_o     <= '0;
      tlbmisc_o <= '0;
      ea_o      <= '0;
      ba_o      <= '0;
      badaddr_o <= '0;
    end else begin
      taken_o <= fire;
      if (fire) begin
        pc_o      <= (vec_sel == VEC_FAST) ? FAST_VEC : EXC_VEC;
        status_o  <= status_nxt;
        exc_o     <= exc_nxt;
        tlbmisc_o <= tlbmisc_nxt;
        if (save_e) begin
          estatus_o <= status_i;
          ea_o      <= ret_addr;
        end
        if (save_b) begin
          bstatus_o <= status_i;
          ba_o      <= ret_addr;
        end
        if (badaddr_we) badaddr_o <= fault_addr_i;
      end
    end
  end
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
  parameter int unsigned       DATA_W   = 32,
  parameter logic [DATA_W-1:0] EXC_VEC  = 32'h0000_0820,
  parameter logic [DATA_W-1:0] FAST_VEC = 32'h0000_0400,
  parameter int unsigned       DBL_BIT  = 14,
  parameter int unsigned       WR_BIT   = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              take_i,
  input logic              exc_req_i,
  input logic [2:0]        exc_class_i,
  input logic [4:0]        exc_cause_i,
  input logic              irq_i,
  input logic [DATA_W-1:0] pc_i,
  input logic [DATA_W-1:0] status_i,
  input logic [DATA_W-1:0] exc_i,
  input logic              taken_o,
  input logic [DATA_W-1:0] pc_o,
  input logic [DATA_W-1:0] status_o,
  input logic [DATA_W-1:0] estatus_o,
  input logic [DATA_W-1:0] bstatus_o,
  input logic [DATA_W-1:0] exc_o,
  input logic [DATA_W-1:0] tlbmisc_o,
  input logic [DATA_W-1:0] ea_o,
  input logic [DATA_W-1:0] ba_o
);
  logic sync_ok;
  assign sync_ok = take_i && exc_req_i && (exc_class_i <= 3'd5);

  a_r2_cause_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_ok && exc_class_i != 3'd5 |=>
      exc_o[6:2] == $past(exc_cause_i) && exc_o[1:0] == $past(exc_i[1:0])
      && exc_o[DATA_W-1:7] == $past(exc_i[DATA_W-1:7]));

  a_r3_fast_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_ok && exc_class_i == 3'd0 && !status_i[2] |=>
      pc_o == FAST_VEC && ea_o == $past(pc_i) + DATA_W'(4)
      && !tlbmisc_o[DBL_BIT] && tlbmisc_o[WR_BIT]);

  a_r4_double_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_ok && exc_class_i == 3'd0 && status_i[2] |=>
      pc_o == EXC_VEC && tlbmisc_o[DBL_BIT] && $stable(estatus_o) && $stable(ea_o));

  a_r6_break_save: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_ok && exc_class_i == 3'd4 && !status_i[2] |=>
      bstatus_o == $past(status_i) && ba_o == $past(pc_i) + DATA_W'(4) && $stable(ea_o));

  a_r8_masked_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !exc_req_i && !status_i[0] |=> !taken_o);

  a_r9_no_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> !taken_o && $stable(status_o) && $stable(pc_o));

  a_r1_entry_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> !status_o[0] && !status_o[1]);
endmodule

bind exc_seq_top exc_seq_chk #(
  .DATA_W(DATA_W), .EXC_VEC(EXC_VEC), .FAST_VEC(FAST_VEC),
  .DBL_BIT(DBL_BIT), .WR_BIT(WR_BIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take_i), .exc_req_i(exc_req_i),
  .exc_class_i(exc_class_i), .exc_cause_i(exc_cause_i), .irq_i(irq_i),
  .pc_i(pc_i), .status_i(status_i), .exc_i(exc_i), .taken_o(taken_o),
  .pc_o(pc_o), .status_o(status_o), .estatus_o(estatus_o),
  .bstatus_o(bstatus_o), .exc_o(exc_o), .tlbmisc_o(tlbmisc_o),
  .ea_o(ea_o), .ba_o(ba_o)
);

// File: tb/sim_exc_seq_top.sv
`timescale 1ns/1ps
module sim_exc_seq_top;
  localparam logic [31:0] GEN  = 32'h0000_0820;
  localparam logic [31:0] FAST = 32'h0000_0400;
  localparam logic [31:0] ST_HI = 32'h00F0_0000;
  localparam logic [31:0] EXC_PAT = 32'hA5A5_A5A5;

  typedef struct packed {
    logic       req;
    logic       irq;
    logic [2:0] cls;
    logic [4:0] cause;
    logic [3:0] st;
    logic       tk;
    logic       fast;
    logic [3:0] est;
    logic [1:0] tlbx;
    logic       sv_e;
    logic       sv_b;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,3'd0,5'd2, 4'b0011,1'b1,1'b0,4'b1000,2'd0,1'b1,1'b0}, // R1 irq
    '{1'b0,1'b1,3'd0,5'd2, 4'b0010,1'b0,1'b0,4'b0000,2'd0,1'b0,1'b0}, // R8 masked
    '{1'b1,1'b0,3'd0,5'd12,4'b0011,1'b1,1'b1,4'b0100,2'd1,1'b1,1'b0}, // R3 fast
    '{1'b1,1'b0,3'd0,5'd12,4'b0100,1'b1,1'b0,4'b0100,2'd2,1'b0,1'b0}, // R4 double
    '{1'b1,1'b0,3'd1,5'd9, 4'b0011,1'b1,1'b0,4'b0100,2'd0,1'b1,1'b0}, // R5 super
    '{1'b1,1'b0,3'd1,5'd9, 4'b0110,1'b1,1'b0,4'b0100,2'd0,1'b0,1'b0}, // R5 nested
    '{1'b1,1'b0,3'd2,5'd3, 4'b0001,1'b1,1'b0,4'b0100,2'd0,1'b1,1'b0}, // R5 trap
    '{1'b1,1'b0,3'd3,5'd5, 4'b0101,1'b1,1'b0,4'b0100,2'd0,1'b0,1'b0}, // R5 illegal nested
    '{1'b1,1'b0,3'd4,5'd7, 4'b0011,1'b1,1'b0,4'b0100,2'd0,1'b0,1'b1}, // R6 break
    '{1'b1,1'b0,3'd4,5'd7, 4'b0111,1'b1,1'b0,4'b0100,2'd0,1'b0,1'b0}, // R6 nested
    '{1'b1,1'b1,3'd2,5'd3, 4'b0001,1'b1,1'b0,4'b0100,2'd0,1'b1,1'b0}, // R8 priority
    '{1'b1,1'b1,3'd6,5'd4, 4'b0001,1'b0,1'b0,4'b0000,2'd0,1'b0,1'b0}, // R8 bad class
    '{1'b1,1'b0,3'd5,5'd6, 4'b0011,1'b1,1'b0,4'b0100,2'd0,1'b1,1'b0}  // R7 unaligned
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic take = 1'b0, req = 1'b0, irq = 1'b0;
  logic [2:0] cls = '0;
  logic [4:0] cause = '0;
  logic [31:0] pc = '0, st = '0, exc = '0, tlb = '0, fa = '0;
  logic taken;
  logic [31:0] pc_o, st_o, est_o, bst_o, exc_o, tlb_o, ea_o, ba_o, bad_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  exc_seq_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .take_i(take), .exc_req_i(req),
    .exc_class_i(cls), .exc_cause_i(cause), .irq_i(irq), .pc_i(pc),
    .status_i(st), .exc_i(exc), .tlbmisc_i(tlb), .fault_addr_i(fa),
    .taken_o(taken), .pc_o(pc_o), .status_o(st_o), .estatus_o(est_o),
    .bstatus_o(bst_o), .exc_o(exc_o), .tlbmisc_o(tlb_o), .ea_o(ea_o),
    .ba_o(ba_o), .badaddr_o(bad_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] o_est, o_ea, o_bst, o_ba, o_bad, o_st, o_pc;
    repeat (3) @(negedge clk);
    chk("R9 reset status", st_o, 32'h0);
    chk("R9 reset pc", pc_o, 32'h0);
    chk("R9 reset taken", {31'h0, taken}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [31:0] e_exc, e_tlb, e_st;
      logic [4:0]  e_cause;
      v = VEC[i];
      o_est = est_o; o_ea = ea_o; o_bst = bst_o; o_ba = ba_o;
      o_bad = bad_o; o_st = st_o; o_pc = pc_o;
      req = v.req; irq = v.irq; cls = v.cls; cause = v.cause;
      pc = 32'h0001_0000 + 32'(i * 16);
      st = ST_HI | {28'h0, v.st};
      exc = EXC_PAT;
      tlb = (v.tlbx == 2'd1) ? 32'h0000_4001 : 32'h0000_0001;
      fa = 32'hDEAD_0000 + 32'(i);
      take = 1'b1;
      @(negedge clk);
      take = 1'b0;
      chk($sformatf("R8 v%0d taken", i), {31'h0, taken}, {31'h0, v.tk});
      if (v.tk) begin
        e_cause = (!v.req && v.irq) ? 5'd2 : v.cause;
        e_st = ST_HI | {28'h0, v.est};
        if (v.req && v.cls == 3'd5) e_exc = {25'h0, e_cause, 2'b00};
        else e_exc = (EXC_PAT & ~32'h7C) | {25'h0, e_cause, 2'b00};
        e_tlb = (v.tlbx == 2'd1) ? 32'h0004_0001 :
                (v.tlbx == 2'd2) ? 32'h0000_4001 : tlb;
        chk($sformatf("R1 v%0d pc", i), pc_o, v.fast ? FAST : GEN);
        chk($sformatf("R5 v%0d status", i), st_o, e_st);
        chk($sformatf("R2 v%0d exc", i), exc_o, e_exc);
        chk($sformatf("R4 v%0d tlbmisc", i), tlb_o, e_tlb);
        chk($sformatf("R3 v%0d estatus", i), est_o, v.sv_e ? st : o_est);
        chk($sformatf("R3 v%0d ea", i), ea_o, v.sv_e ? pc + 32'd4 : o_ea);
        chk($sformatf("R6 v%0d bstatus", i), bst_o, v.sv_b ? st : o_bst);
        chk($sformatf("R6 v%0d ba", i), ba_o, v.sv_b ? pc + 32'd4 : o_ba);
        chk($sformatf("R7 v%0d badaddr", i), bad_o,
            (v.req && v.cls == 3'd5) ? fa : o_bad);
      end else begin
        chk($sformatf("R8 v%0d status held", i), st_o, o_st);
        chk($sformatf("R8 v%0d pc held", i), pc_o, o_pc);
        chk($sformatf("R8 v%0d estatus held", i), est_o, o_est);
      end
    end

    // R9: request present but no strobe
    o_st = st_o; o_pc = pc_o; o_ea = ea_o;
    req = 1'b1; cls = 3'd2; cause = 5'd3; st = 32'h0000_0003; pc = 32'h0000_9000;
    @(negedge clk);
    chk("R9 no strobe taken", {31'h0, taken}, 32'h0);
    chk("R9 no strobe status", st_o, o_st);
    chk("R9 no strobe ea", ea_o, o_ea);
    req = 1'b0;

    // R9: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 rerun status", st_o, 32'h0);
    chk("R9 rerun ea", ea_o, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule